// File: doc/BRIEF.md
# Stack Pointer Range Guard

This block watches the stack pointer that a processor core reports and compares it, on every cycle the core marks as valid, against a programmable floor and ceiling. A pointer below the floor raises an underflow event. A pointer above the ceiling raises an overflow event. Each check has its own enable, its own sticky status bit, its own interrupt enable and its own write-one-to-clear bit. The two bits sit at the same positions in every one of these words.

When the first violation arrives while no stack status bit is set, the guard also records the program counter the core reported in that cycle. Software reads the recorded value after the interrupt fires. A later violation does not overwrite it until both status bits have been cleared. A small word-addressed register port gives access to the bounds, the enables and the status. The interrupt output is a level.

Top module: `stack_guard`

## Requirements
- R1: After reset the floor reads 0x00000000, the ceiling reads 0xFFFFFFFF, and the status, check enable, interrupt enable and captured PC registers read 0. The interrupt output is low.
- R2: Consider a clock edge where core valid is high, check enable bit 8 is set and the stack pointer is strictly below the floor. That edge sets status bit 8 (underflow). A pointer equal to the floor sets nothing.
- R3: Consider a clock edge where core valid is high, check enable bit 9 is set and the stack pointer is strictly above the ceiling. That edge sets status bit 9 (overflow). A pointer equal to the ceiling sets nothing.
- R4: No status bit is set in a cycle where core valid is low. No status bit is set while its check enable bit is 0.
- R5: Writing 1 to bit 8 or bit 9 of the clear register clears that status bit only. A 0 in a clear bit has no effect. If a violation and a clear of the same bit arrive in the same cycle, the bit stays set.
- R6: The captured PC register loads the core PC on the edge that sets a status bit, but only if both status bits were 0 before that edge. While either bit is set, the captured PC holds its value.
- R7: The interrupt output is high exactly when some status bit is set and the interrupt enable bit at the same position (8 or 9) is also set.
- R8: The register map uses word offsets on busAddr: 0 status (read-only), 1 check enable, 2 interrupt enable, 3 clear (reads 0), 4 floor, 5 ceiling, 6 captured PC (read-only). The enable registers keep only bits 8 and 9. Writes to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | Access is a write when high |
| busAddr | input | REG_AW | Register word offset |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr (combinational) |
| coreValid | input | 1 | Core reports a valid SP/PC this cycle |
| coreSp | input | DATA_W | Core stack pointer |
| corePc | input | DATA_W | Core program counter |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker runs on every cycle. It checks that an enabled out-of-range pointer always sets its status bit on the next edge, and that idle core cycles never raise a status bit. It also checks that a set status bit persists until its own clear write, and that the captured PC stays frozen while any status bit is set. Only the bench scenarios can show the remaining behaviour: exact equality at the bounds, the reset values, the read-only and masked register behaviour, the interrupt gating by enable, and the case where a clear and a violation collide in one cycle.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int UNDER_BIT = 8;
  localparam int OVER_BIT  = 9;
  localparam int NUM_EVT   = 2;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_CHKEN  = 1;
  localparam int ADDR_IRQEN  = 2;
  localparam int ADDR_CLEAR  = 3;
  localparam int ADDR_FLOOR  = 4;
  localparam int ADDR_CEIL   = 5;
  localparam int ADDR_PC     = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic wrFloor;
    logic wrCeil;
    logic capPc;
  } dpStrobe_t;

  function automatic int evtBit(input int idx);
    return (idx == 0) ? UNDER_BIT : OVER_BIT;
  endfunction
endpackage

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] coreSp,
  input  logic [DATA_W-1:0] corePc,
  output logic [DATA_W-1:0] floorQ,
  output logic [DATA_W-1:0] ceilQ,
  output logic [DATA_W-1:0] pcQ,
  output logic              spBelow,
  output logic              spAbove
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      floorQ <= '0;
      ceilQ  <= '1;
      pcQ    <= '0;
    end else begin
      if (strb.wrFloor) floorQ <= wrData;
      if (strb.wrCeil)  ceilQ  <= wrData;
      if (strb.capPc)   pcQ    <= corePc;
    end
  end

  assign spBelow = coreSp < floorQ;
  assign spAbove = coreSp > ceilQ;
endmodule

// File: rtl/sg_control.sv
module sg_control
  import sg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [NUM_EVT-1:0] wrBits,
  input  logic              coreValid,
  input  logic              spBelow,
  input  logic              spAbove,
  input  logic [DATA_W-1:0] floorQ,
  input  logic [DATA_W-1:0] ceilQ,
  input  logic [DATA_W-1:0] pcQ,
  output dpStrobe_t         strb,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] enWord,
  output logic [DATA_W-1:0] ienWord,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  localparam logic [REG_AW-1:0] A_STATUS = REG_AW'(ADDR_STATUS);
  localparam logic [REG_AW-1:0] A_CHKEN  = REG_AW'(ADDR_CHKEN);
  localparam logic [REG_AW-1:0] A_IRQEN  = REG_AW'(ADDR_IRQEN);
  localparam logic [REG_AW-1:0] A_CLEAR  = REG_AW'(ADDR_CLEAR);
  localparam logic [REG_AW-1:0] A_FLOOR  = REG_AW'(ADDR_FLOOR);
  localparam logic [REG_AW-1:0] A_CEIL   = REG_AW'(ADDR_CEIL);
  localparam logic [REG_AW-1:0] A_PC     = REG_AW'(ADDR_PC);

  logic busWr;
  logic wrChkEn, wrIrqEn, wrClear;
  logic [NUM_EVT-1:0] cmp, hit, evtSt, evtEn, evtIen;

  assign busWr   = busValid && busWrite;
  assign wrChkEn = busWr && (busAddr == A_CHKEN);
  assign wrIrqEn = busWr && (busAddr == A_IRQEN);
  assign wrClear = busWr && (busAddr == A_CLEAR);
  assign cmp     = {spAbove, spBelow};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign hit[i] = coreValid && evtEn[i] && cmp[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        evtSt[i]  <= 1'b0;
        evtEn[i]  <= 1'b0;
        evtIen[i] <= 1'b0;
      end else begin
        // a new violation wins over a clear in the same cycle
        if (hit[i])                       evtSt[i] <= 1'b1;
        else if (wrClear && wrBits[i])    evtSt[i] <= 1'b0;
        if (wrChkEn) evtEn[i]  <= wrBits[i];
        if (wrIrqEn) evtIen[i] <= wrBits[i];
      end
    end
  end

  always_comb begin
    statusWord = '0;
    enWord     = '0;
    ienWord    = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      statusWord[evtBit(i)] = evtSt[i];
      enWord[evtBit(i)]     = evtEn[i];
      ienWord[evtBit(i)]    = evtIen[i];
    end
  end

  assign irq = |(evtSt & evtIen);

  always_comb begin
    strb.wrFloor = busWr && (busAddr == A_FLOOR);
    strb.wrCeil  = busWr && (busAddr == A_CEIL);
    strb.capPc   = (|hit) && !(|evtSt);
  end

  always_comb begin
    case (busAddr)
      A_STATUS: busRdata = statusWord;
      A_CHKEN:  busRdata = enWord;
      A_IRQEN:  busRdata = ienWord;
      A_FLOOR:  busRdata = floorQ;
      A_CEIL:   busRdata = ceilQ;
      A_PC:     busRdata = pcQ;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import sg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              coreValid,
  input  logic [DATA_W-1:0] coreSp,
  input  logic [DATA_W-1:0] corePc,
  output logic              irq
);
  dpStrobe_t         strb;
  logic [DATA_W-1:0] floorQ, ceilQ, pcQ;
  logic [DATA_W-1:0] statusWord, enWord, ienWord;
  logic              spBelow, spAbove;
  logic [NUM_EVT-1:0] wrBits;

  assign wrBits = {busWdata[OVER_BIT], busWdata[UNDER_BIT]};

  sg_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWdata),
    .coreSp(coreSp), .corePc(corePc),
    .floorQ(floorQ), .ceilQ(ceilQ), .pcQ(pcQ),
    .spBelow(spBelow), .spAbove(spAbove)
  );

  sg_control #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .wrBits(wrBits), .coreValid(coreValid),
    .spBelow(spBelow), .spAbove(spAbove),
    .floorQ(floorQ), .ceilQ(ceilQ), .pcQ(pcQ),
    .strb(strb), .statusWord(statusWord), .enWord(enWord), .ienWord(ienWord),
    .busRdata(busRdata), .irq(irq)
  );
endmodule

// File: rtl/sg_checker.sv
module sg_checker
  import sg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [REG_AW-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              coreValid,
  input logic [DATA_W-1:0] coreSp,
  input logic [DATA_W-1:0] floorQ,
  input logic [DATA_W-1:0] ceilQ,
  input logic [DATA_W-1:0] pcQ,
  input logic [DATA_W-1:0] statusWord,
  input logic [DATA_W-1:0] enWord
);
  logic clrWr;
  assign clrWr = busValid && busWrite && (busAddr == REG_AW'(ADDR_CLEAR));

  a_r2_under_sets: assert property (@(posedge clk) disable iff (!rstN)
    coreValid && enWord[UNDER_BIT] && (coreSp < floorQ) |=> statusWord[UNDER_BIT]);

  a_r3_over_sets: assert property (@(posedge clk) disable iff (!rstN)
    coreValid && enWord[OVER_BIT] && (coreSp > ceilQ) |=> statusWord[OVER_BIT]);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !coreValid |=> !$rose(statusWord[UNDER_BIT]) && !$rose(statusWord[OVER_BIT]));

  a_r5_under_sticky: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[UNDER_BIT] && !(clrWr && busWdata[UNDER_BIT]) |=> statusWord[UNDER_BIT]);

  a_r5_over_sticky: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[OVER_BIT] && !(clrWr && busWdata[OVER_BIT]) |=> statusWord[OVER_BIT]);

  a_r6_pc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[OVER_BIT] || statusWord[UNDER_BIT]) |=> $stable(pcQ));
endmodule

bind stack_guard sg_checker #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .coreValid(coreValid),
  .coreSp(coreSp), .floorQ(floorQ), .ceilQ(ceilQ), .pcQ(pcQ),
  .statusWord(statusWord), .enWord(enWord)
);

// File: tb/stack_guard_test.sv
module stack_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          coreValid = 1'b0;
  logic [DW-1:0] coreSp = '0, corePc = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          isIrq;
    logic [AW-1:0] addr;
    logic [DW-1:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  item_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_guard #(.DATA_W(DW), .REG_AW(AW)) uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .coreValid(coreValid), .coreSp(coreSp), .corePc(corePc), .irq(irq)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (cur.isIrq) begin
        if (irq !== cur.exp[0]) begin
          errors++;
          $display("FAIL %s irq actual=%0b expected=%0b", cur.tag, irq, cur.exp[0]);
        end
      end else if (busRdata !== cur.exp) begin
        errors++;
        $display("FAIL %s reg%0d actual=%h expected=%h", cur.tag, cur.addr, busRdata, cur.exp);
      end
    end
  end

  task automatic expectReg(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    item_t it;
    @(posedge clk); #1;
    busAddr = a;
    it.isIrq = 1'b0; it.addr = a; it.exp = e; it.tag = t;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expectIrq(input bit e, input string t);
    item_t it;
    @(posedge clk); #1;
    it.isIrq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.tag = t;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic regWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic coreStep(input bit v, input logic [DW-1:0] sp, input logic [DW-1:0] pc);
    @(posedge clk); #1;
    coreValid = v; coreSp = sp; corePc = pc;
    @(posedge clk); #1;
    coreValid = 1'b0;
  endtask

  task automatic bothStep(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] sp, input logic [DW-1:0] pc);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    coreValid = 1'b1; coreSp = sp; corePc = pc;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0; coreValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    expectReg(4'd0, 32'h0, "R1 status");
    expectReg(4'd1, 32'h0, "R1 chken");
    expectReg(4'd2, 32'h0, "R1 irqen");
    expectReg(4'd4, 32'h0, "R1 floor");
    expectReg(4'd5, 32'hFFFF_FFFF, "R1 ceil");
    expectReg(4'd6, 32'h0, "R1 pc");
    expectIrq(1'b0, "R1 irq");

    regWrite(4'd4, 32'h1000);
    regWrite(4'd5, 32'h2000);
    regWrite(4'd1, 32'h300);
    expectReg(4'd1, 32'h300, "R8 chken");

    // equality at the bounds
    coreStep(1'b1, 32'h1000, 32'h11);
    expectReg(4'd0, 32'h0, "R2 sp==floor");
    coreStep(1'b1, 32'h2000, 32'h12);
    expectReg(4'd0, 32'h0, "R3 sp==ceil");

    // R4 idle core and disabled checks
    coreStep(1'b0, 32'h10, 32'h13);
    expectReg(4'd0, 32'h0, "R4 core idle");
    regWrite(4'd1, 32'h0);
    coreStep(1'b1, 32'h10, 32'h14);
    coreStep(1'b1, 32'hFFFF_0000, 32'h15);
    expectReg(4'd0, 32'h0, "R4 checks off");
    expectReg(4'd6, 32'h0, "R4 pc untouched");
    regWrite(4'd1, 32'h300);

    // R2 underflow, first capture
    coreStep(1'b1, 32'h0FFF, 32'hA0);
    expectReg(4'd0, 32'h100, "R2 underflow");
    expectReg(4'd6, 32'hA0, "R6 first capture");
    expectIrq(1'b0, "R7 irq masked");

    // R3 overflow, no recapture
    coreStep(1'b1, 32'h3000, 32'hB0);
    expectReg(4'd0, 32'h300, "R3 overflow");
    expectReg(4'd6, 32'hA0, "R6 pc held");

    // R7 interrupt gating, R5 clears
    regWrite(4'd2, 32'h200);
    expectIrq(1'b1, "R7 over enabled");
    expectReg(4'd2, 32'h200, "R8 irqen");
    regWrite(4'd3, 32'h100);
    expectReg(4'd0, 32'h200, "R5 clear bit8 only");
    expectIrq(1'b1, "R7 still over");
    regWrite(4'd2, 32'h100);
    expectIrq(1'b0, "R7 enable mismatch");
    regWrite(4'd3, 32'h0);
    expectReg(4'd0, 32'h200, "R5 zero write");
    regWrite(4'd3, 32'h200);
    expectReg(4'd0, 32'h0, "R5 clear bit9");
    expectIrq(1'b0, "R7 all clear");

    // R6 recapture after full clear
    coreStep(1'b1, 32'h3001, 32'hC0);
    expectReg(4'd0, 32'h200, "R3 overflow again");
    expectReg(4'd6, 32'hC0, "R6 recapture");

    // R5 clear and violation collide
    bothStep(4'd3, 32'h200, 32'h5000, 32'hD0);
    expectReg(4'd0, 32'h200, "R5 set wins");
    expectReg(4'd6, 32'hC0, "R6 no capture while set");

    // R8 read-only and masking
    regWrite(4'd0, 32'h0);
    expectReg(4'd0, 32'h200, "R8 status read-only");
    regWrite(4'd6, 32'h1234);
    expectReg(4'd6, 32'hC0, "R8 pc read-only");
    expectReg(4'd3, 32'h0, "R8 clear reads zero");
    regWrite(4'd1, 32'hFFFF_FFFF);
    expectReg(4'd1, 32'h300, "R8 enable mask");
    regWrite(4'd4, 32'hDEAD_BEEF);
    expectReg(4'd4, 32'hDEAD_BEEF, "R8 floor readback");

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule